// File: doc/BRIEF.md
# Flash Command and Status Controller

This block is the control core of a byte-wide NOR-style flash. Hosts issue bus write cycles, each marked by a low pulse on an active-low write strobe. Multi-cycle command sequences drive a program or sector-erase operation. A cycle counter stands in for the time the cell array would take, and a small register array holds the contents. While an operation runs, an active-low ready/busy output is held low. Reads then return a status byte instead of array data.

An erase can be suspended and later resumed. While it is suspended, the untouched sectors can be read normally. A hardware reset input aborts work in progress, and so does a low-supply flag. A glitch filter on the write strobe rejects pulses that are too short to be real bus cycles.

The memory has 2^SECT_W sectors. The top SECT_W address bits select the sector, and the low LOC_W bits select a byte inside it. The address bits between them are not decoded, so those addresses alias.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: Programming takes four write cycles: AAh@555h, 55h@2AAh, A0h@555h, then data@target. The ready/busy output goes low only after the fourth cycle is accepted, and stays low for about PGM_CYC clocks. The stored byte then becomes old AND new, so programming can only clear bits.
- R2: Erasing takes six write cycles: AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, then 30h at any address in the target sector. Busy starts only after the sixth cycle and lasts about ERS_CYC clocks. Afterwards every byte of that sector reads FFh, and other sectors are unchanged.
- R3: A wrong data value or wrong address at any step of a sequence returns the decoder to idle. No operation starts, and a later complete sequence works normally.
- R4: While a program or erase runs, all new command sequences are ignored.
- R5: The suspend command (B0h, any address) is accepted only while an erase runs. It releases ready/busy to high, and the operation state moves to suspended only from a running erase. During suspension, reads outside the erasing sector return array data. B0h during a program is ignored.
- R6: While an operation runs, every read returns a status byte with bit 6 = flag A and bit 2 = flag B; all other bits are 0. Both flags are cleared when the operation starts. Flag A inverts after every read. Flag B inverts only after a read that falls in the erasing sector. During suspension, reads in the erasing sector return the same byte, but only flag B inverts.
- R7: The resume command (30h, any address) during suspension continues the erase with its remaining count. The count is held while suspended.
- R8: The hardware reset input (active low) always forces ready/busy low and output enable low. If it stays low for at least RST_MIN_CYC clocks, any operation is aborted and the decoder returns to idle. A shorter pulse does not abort.
- R9: While the low-supply flag is high, any operation is aborted, the decoder is held idle and every write is ignored.
- R10: A strobe low for fewer than GLITCH_MIN sampled clocks is not a write cycle and does not change the decoder state.
- R11: After reset the block is ready, its outputs are enabled, and every byte reads FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset of the logic |
| hw_reset_n | input | 1 | Active-low hardware reset request |
| low_supply | input | 1 | High while supply is below the write lockout level |
| we_n | input | 1 | Active-low write strobe, sampled each clock |
| rd_en | input | 1 | One-clock read request; data is valid after the next edge |
| addr | input | ADDR_W | Shared read/write address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data or status byte |
| rdata_oe | output | 1 | Data output enable (low means high impedance) |
| rdy_busy_n | output | 1 | Ready (1) or busy (0) |

## Verification
A status read and the toggle state of the flags fall in the same clock when a read hits the erasing sector. The bench alternates reads between the erasing sector and a foreign sector, during the erase and again during suspension. It compares each returned byte against a model in which flag B moves only on in-sector reads and flag A freezes while suspended. A second collision is a lockout arriving mid-sequence or mid-operation. A low-supply pulse between two halves of a command sequence, and a short hardware reset during a program, are each judged at the ready/busy pin and through later reads of the target bytes.

// File: rtl/flash_ctrl_pkg.sv
package flash_ctrl_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_UNL1, SQ_UNL2, SQ_PGM, SQ_ERS1, SQ_ERS2, SQ_ERS3
  } seq_t;

  typedef enum logic [1:0] {
    EN_IDLE, EN_PGM, EN_ERS, EN_SUSP
  } eng_t;

  localparam logic [7:0] CD_KEY_A    = 8'hAA;
  localparam logic [7:0] CD_KEY_B    = 8'h55;
  localparam logic [7:0] CD_PROGRAM  = 8'hA0;
  localparam logic [7:0] CD_ERS_ARM  = 8'h80;
  localparam logic [7:0] CD_GO       = 8'h30;
  localparam logic [7:0] CD_SUSPEND  = 8'hB0;

  // status layout: bit 6 = per-read flag, bit 2 = sector flag
  function automatic logic [7:0] status_byte(input logic flag_a, input logic flag_b);
    status_byte = {1'b0, flag_a, 3'b000, flag_b, 2'b00};
  endfunction

  // programming only clears bits
  function automatic logic [7:0] program_merge(input logic [7:0] old_v, input logic [7:0] new_v);
    program_merge = old_v & new_v;
  endfunction

endpackage

// File: rtl/flash_we_filter.sv
module flash_we_filter #(
  parameter int ADDR_W     = 11,
  parameter int GLITCH_MIN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic              wr_evt,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data
);
  localparam int CNT_W = $clog2(GLITCH_MIN + 1);

  logic             we_q;
  logic [CNT_W-1:0] low_cnt;
  logic             long_enough;

  assign long_enough = (low_cnt >= CNT_W'(GLITCH_MIN));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_q    <= 1'b1;
      low_cnt <= '0;
      wr_evt  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      we_q   <= we_n;
      wr_evt <= en && we_n && !we_q && long_enough;
      if (!we_n) begin
        if (!long_enough) low_cnt <= low_cnt + 1'b1;
        wr_addr <= addr;
        wr_data <= wdata;
      end else begin
        low_cnt <= '0;
      end
    end
  end

  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> !wr_evt); // R10

endmodule

// File: rtl/flash_rst_filter.sv
module flash_rst_filter #(
  parameter int RST_MIN_CYC = 63
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_reset_n,
  output logic rst_hit
);
  localparam int CNT_W = $clog2(RST_MIN_CYC + 1);

  logic [CNT_W-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                            low_cnt <= '0;
    else if (hw_reset_n)                   low_cnt <= '0;
    else if (low_cnt != CNT_W'(RST_MIN_CYC)) low_cnt <= low_cnt + 1'b1;
  end

  assign rst_hit = !hw_reset_n && (low_cnt == CNT_W'(RST_MIN_CYC));

  AST_HIT_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    rst_hit |-> $past(!hw_reset_n)); // R8

endmodule

// File: rtl/flash_seq_decoder.sv
module flash_seq_decoder
  import flash_ctrl_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              wr_evt,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  eng_t              eng_st,
  output logic              start_pgm,
  output logic              start_ers,
  output logic              suspend_req,
  output logic              resume_req
);
  localparam logic [ADDR_W-1:0] A_FIRST  = ADDR_W'(11'h555);
  localparam logic [ADDR_W-1:0] A_SECOND = ADDR_W'(11'h2AA);

  seq_t seq, seq_nxt;
  logic key_a_ok, key_b_ok;

  assign key_a_ok = (wr_data == CD_KEY_A) && (wr_addr == A_FIRST);
  assign key_b_ok = (wr_data == CD_KEY_B) && (wr_addr == A_SECOND);

  always_comb begin
    seq_nxt   = seq;
    start_pgm = 1'b0;
    start_ers = 1'b0;
    if (clear || eng_st != EN_IDLE) begin
      seq_nxt = SQ_IDLE;
    end else if (wr_evt) begin
      unique case (seq)
        SQ_IDLE: seq_nxt = key_a_ok ? SQ_UNL1 : SQ_IDLE;
        SQ_UNL1: seq_nxt = key_b_ok ? SQ_UNL2 : SQ_IDLE;
        SQ_UNL2: begin
          if (wr_addr != A_FIRST)          seq_nxt = SQ_IDLE;
          else if (wr_data == CD_PROGRAM)  seq_nxt = SQ_PGM;
          else if (wr_data == CD_ERS_ARM)  seq_nxt = SQ_ERS1;
          else                             seq_nxt = SQ_IDLE;
        end
        SQ_PGM: begin
          start_pgm = 1'b1;
          seq_nxt   = SQ_IDLE;
        end
        SQ_ERS1: seq_nxt = key_a_ok ? SQ_ERS2 : SQ_IDLE;
        SQ_ERS2: seq_nxt = key_b_ok ? SQ_ERS3 : SQ_IDLE;
        SQ_ERS3: begin
          start_ers = (wr_data == CD_GO);
          seq_nxt   = SQ_IDLE;
        end
        default: seq_nxt = SQ_IDLE;
      endcase
    end
  end

  assign suspend_req = !clear && wr_evt && eng_st == EN_ERS  && wr_data == CD_SUSPEND;
  assign resume_req  = !clear && wr_evt && eng_st == EN_SUSP && wr_data == CD_GO;

  always_ff @(posedge clk) begin
    if (!rst_n) seq <= SQ_IDLE;
    else        seq <= seq_nxt;
  end

  AST_SEQ_RESET_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (seq == SQ_IDLE)); // R3

endmodule

// File: rtl/flash_op_engine.sv
module flash_op_engine
  import flash_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 11,
  parameter int SECT_W  = 2,
  parameter int LOC_W   = 3,
  parameter int PGM_CYC = 60,
  parameter int ERS_CYC = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              start_pgm,
  input  logic              start_ers,
  input  logic              suspend_req,
  input  logic              resume_req,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output eng_t              st,
  output logic [7:0]        rdata
);
  localparam int MEM_AW    = SECT_W + LOC_W;
  localparam int MEM_DEPTH = 1 << MEM_AW;
  localparam int LOC_DEPTH = 1 << LOC_W;
  localparam int MAX_CYC   = (PGM_CYC > ERS_CYC) ? PGM_CYC : ERS_CYC;
  localparam int TMR_W     = $clog2(MAX_CYC + 1);

  function automatic logic [SECT_W-1:0] sector_of(input logic [ADDR_W-1:0] a);
    sector_of = a[ADDR_W-1 -: SECT_W];
  endfunction

  function automatic logic [MEM_AW-1:0] slot_of(input logic [ADDR_W-1:0] a);
    slot_of = {a[ADDR_W-1 -: SECT_W], a[LOC_W-1:0]};
  endfunction

  logic [7:0]        mem [MEM_DEPTH];
  logic [TMR_W-1:0]  timer;
  logic [MEM_AW-1:0] p_slot;
  logic [7:0]        p_data;
  logic [SECT_W-1:0] e_sect;
  logic              flag_a, flag_b;
  logic              rd_in_esect;
  logic              unused_mid;

  assign rd_in_esect = (sector_of(rd_addr) == e_sect);
  assign unused_mid  = ^{rd_addr[ADDR_W-SECT_W-1:LOC_W], cmd_addr[ADDR_W-SECT_W-1:LOC_W]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= EN_IDLE;
      timer  <= '0;
      p_slot <= '0;
      p_data <= '0;
      e_sect <= '0;
      flag_a <= 1'b0;
      flag_b <= 1'b0;
      rdata  <= 8'hFF;
      for (int i = 0; i < MEM_DEPTH; i++) mem[i] <= 8'hFF;
    end else begin
      if (rd_en) begin
        if (st == EN_PGM || st == EN_ERS) begin
          rdata  <= status_byte(flag_a, flag_b);
          flag_a <= ~flag_a;
          if (st == EN_ERS && rd_in_esect) flag_b <= ~flag_b;
        end else if (st == EN_SUSP && rd_in_esect) begin
          rdata  <= status_byte(flag_a, flag_b);
          flag_b <= ~flag_b;
        end else begin
          rdata <= mem[slot_of(rd_addr)];
        end
      end
      if (clear) begin
        st <= EN_IDLE;
      end else begin
        unique case (st)
          EN_IDLE: begin
            if (start_pgm) begin
              st     <= EN_PGM;
              timer  <= TMR_W'(PGM_CYC);
              p_slot <= slot_of(cmd_addr);
              p_data <= cmd_data;
              flag_a <= 1'b0;
              flag_b <= 1'b0;
            end else if (start_ers) begin
              st     <= EN_ERS;
              timer  <= TMR_W'(ERS_CYC);
              e_sect <= sector_of(cmd_addr);
              flag_a <= 1'b0;
              flag_b <= 1'b0;
            end
          end
          EN_PGM: begin
            if (timer == '0) begin
              mem[p_slot] <= program_merge(mem[p_slot], p_data);
              st          <= EN_IDLE;
            end else begin
              timer <= timer - 1'b1;
            end
          end
          EN_ERS: begin
            if (suspend_req) begin
              st <= EN_SUSP;
            end else if (timer == '0) begin
              for (int i = 0; i < LOC_DEPTH; i++) mem[{e_sect, LOC_W'(i)}] <= 8'hFF;
              st <= EN_IDLE;
            end else begin
              timer <= timer - 1'b1;
            end
          end
          EN_SUSP: if (resume_req) st <= EN_ERS;
          default: st <= EN_IDLE;
        endcase
      end
    end
  end

  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (st != EN_IDLE) |-> !(start_pgm || start_ers)); // R4
  AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (st == EN_IDLE)); // R9
  AST_SUSP_FROM_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == EN_SUSP) |-> ($past(st) == EN_ERS || $past(st) == EN_SUSP)); // R5
  AST_TIMER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == EN_SUSP && $past(st) == EN_SUSP) |-> $stable(timer)); // R7

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_ctrl_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int SECT_W      = 2,
  parameter int LOC_W       = 3,
  parameter int PGM_CYC     = 60,
  parameter int ERS_CYC     = 200,
  parameter int RST_MIN_CYC = 63,
  parameter int GLITCH_MIN  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_reset_n,
  input  logic              low_supply,
  input  logic              we_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              rdata_oe,
  output logic              rdy_busy_n
);
  logic              wr_evt, rst_hit, clear, wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0]        wr_data;
  logic              start_pgm, start_ers, suspend_req, resume_req;
  logic              running;
  eng_t              eng_st;

  assign wr_en = !low_supply && hw_reset_n;
  assign clear = rst_hit || low_supply;

  flash_we_filter #(.ADDR_W(ADDR_W), .GLITCH_MIN(GLITCH_MIN)) u_we_filter (
    .clk(clk), .rst_n(rst_n), .en(wr_en), .we_n(we_n), .addr(addr), .wdata(wdata),
    .wr_evt(wr_evt), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  flash_rst_filter #(.RST_MIN_CYC(RST_MIN_CYC)) u_rst_filter (
    .clk(clk), .rst_n(rst_n), .hw_reset_n(hw_reset_n), .rst_hit(rst_hit)
  );

  flash_seq_decoder #(.ADDR_W(ADDR_W)) u_decoder (
    .clk(clk), .rst_n(rst_n), .clear(clear), .wr_evt(wr_evt), .wr_addr(wr_addr),
    .wr_data(wr_data), .eng_st(eng_st), .start_pgm(start_pgm), .start_ers(start_ers),
    .suspend_req(suspend_req), .resume_req(resume_req)
  );

  flash_op_engine #(
    .ADDR_W(ADDR_W), .SECT_W(SECT_W), .LOC_W(LOC_W), .PGM_CYC(PGM_CYC), .ERS_CYC(ERS_CYC)
  ) u_engine (
    .clk(clk), .rst_n(rst_n), .clear(clear), .start_pgm(start_pgm), .start_ers(start_ers),
    .suspend_req(suspend_req), .resume_req(resume_req), .cmd_addr(wr_addr),
    .cmd_data(wr_data), .rd_en(rd_en), .rd_addr(addr), .st(eng_st), .rdata(rdata)
  );

  assign running    = (eng_st == EN_PGM) || (eng_st == EN_ERS);
  assign rdy_busy_n = hw_reset_n && !running;
  assign rdata_oe   = hw_reset_n;

  AST_LOCKOUT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (low_supply && $past(low_supply)) |-> !wr_evt); // R9

endmodule

// File: tb/flash_cmd_ctrl_bench.sv
module flash_cmd_ctrl_bench;
  localparam int ADDR_W = 11;
  localparam int PGM_CYC = 60;
  localparam int ERS_CYC = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hw_reset_n = 1'b1;
  logic low_supply = 1'b0;
  logic we_n = 1'b1;
  logic rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic rdata_oe, rdy_busy_n;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  flash_cmd_ctrl u_flash_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .hw_reset_n(hw_reset_n), .low_supply(low_supply),
    .we_n(we_n), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .rdata_oe(rdata_oe), .rdy_busy_n(rdy_busy_n)
  );

  function automatic logic [7:0] stat(input logic fa, input logic fb);
    stat = 8'h00;
    stat[6] = fa;
    stat[2] = fb;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d, input int lows = 2);
    @(negedge clk);
    addr = a; wdata = d; we_n = 1'b0;
    repeat (lows - 1) @(negedge clk);
    @(negedge clk);
    we_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic do_program(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'hA0); wr(a, d);
  endtask

  task automatic do_erase(input logic [ADDR_W-1:0] sa);
    wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'h80);
    wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(sa, 8'h30);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R11 ready", {7'd0, rdy_busy_n}, 8'd1);
    chk("R11 oe", {7'd0, rdata_oe}, 8'd1);
    rd(11'h000, v); chk("R11 blank", v, 8'hFF);
  endtask

  task automatic t_program();
    logic [7:0] v;
    wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'hA0);
    chk("R1 ready before 4th", {7'd0, rdy_busy_n}, 8'd1);
    wr(11'h123, 8'h5A);
    chk("R1 busy after 4th", {7'd0, rdy_busy_n}, 8'd0);
    repeat (40) @(negedge clk);
    chk("R1 still busy", {7'd0, rdy_busy_n}, 8'd0);
    repeat (30) @(negedge clk);
    chk("R1 ready after", {7'd0, rdy_busy_n}, 8'd1);
    rd(11'h123, v); chk("R1 data", v, 8'h5A);
    do_program(11'h123, 8'h0F);
    repeat (PGM_CYC + 10) @(negedge clk);
    rd(11'h123, v); chk("R1 and-merge", v, 8'h0A);
  endtask

  task automatic t_erase();
    logic [7:0] v;
    do_program(11'h201, 8'h33); repeat (PGM_CYC + 10) @(negedge clk);
    do_program(11'h400, 8'h00); repeat (PGM_CYC + 10) @(negedge clk);
    wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'h80);
    wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55);
    chk("R2 ready before 6th", {7'd0, rdy_busy_n}, 8'd1);
    wr(11'h200, 8'h30);
    chk("R2 busy after 6th", {7'd0, rdy_busy_n}, 8'd0);
    repeat (ERS_CYC + 10) @(negedge clk);
    chk("R2 ready after", {7'd0, rdy_busy_n}, 8'd1);
    rd(11'h201, v); chk("R2 erased", v, 8'hFF);
    rd(11'h400, v); chk("R2 other sector kept", v, 8'h00);
  endtask

  task automatic t_bad_seq();
    logic [7:0] v;
    wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'h77); wr(11'h100, 8'h00);
    chk("R3 bad data no start", {7'd0, rdy_busy_n}, 8'd1);
    rd(11'h100, v); chk("R3 bad data no write", v, 8'hFF);
    wr(11'h555, 8'hAA); wr(11'h123, 8'h55); wr(11'h555, 8'hA0); wr(11'h101, 8'h10);
    chk("R3 bad addr no start", {7'd0, rdy_busy_n}, 8'd1);
    rd(11'h101, v); chk("R3 bad addr no write", v, 8'hFF);
    do_program(11'h101, 8'h10); repeat (PGM_CYC + 10) @(negedge clk);
    rd(11'h101, v); chk("R3 recovers", v, 8'h10);
  endtask

  task automatic t_busy_ignore();
    logic [7:0] v;
    do_program(11'h300, 8'hF0);
    do_program(11'h301, 8'h00);
    wr(11'h000, 8'hB0);
    chk("R5 suspend ignored in program", {7'd0, rdy_busy_n}, 8'd0);
    repeat (PGM_CYC + 10) @(negedge clk);
    rd(11'h300, v); chk("R4 first program done", v, 8'hF0);
    rd(11'h301, v); chk("R4 nested program ignored", v, 8'hFF);
  endtask

  task automatic t_suspend();
    logic [7:0] v;
    do_program(11'h601, 8'h12); repeat (PGM_CYC + 10) @(negedge clk);
    do_erase(11'h600);
    rd(11'h605, v); chk("R6 read1", v, stat(1'b0, 1'b0));
    rd(11'h605, v); chk("R6 read2", v, stat(1'b1, 1'b1));
    rd(11'h005, v); chk("R6 foreign read", v, stat(1'b0, 1'b0));
    rd(11'h605, v); chk("R6 read4", v, stat(1'b1, 1'b0));
    repeat (130) @(negedge clk);
    chk("R5 busy before suspend", {7'd0, rdy_busy_n}, 8'd0);
    wr(11'h000, 8'hB0);
    chk("R5 ready in suspend", {7'd0, rdy_busy_n}, 8'd1);
    rd(11'h601, v); chk("R6 susp read1", v, stat(1'b0, 1'b1));
    rd(11'h601, v); chk("R6 susp read2", v, stat(1'b0, 1'b0));
    rd(11'h123, v); chk("R5 array read in suspend", v, 8'h0A);
    rd(11'h601, v); chk("R6 susp read3", v, stat(1'b0, 1'b1));
    repeat (300) @(negedge clk);
    chk("R5 stays suspended", {7'd0, rdy_busy_n}, 8'd1);
    wr(11'h600, 8'h30);
    chk("R7 busy after resume", {7'd0, rdy_busy_n}, 8'd0);
    repeat (20) @(negedge clk);
    chk("R7 still busy", {7'd0, rdy_busy_n}, 8'd0);
    repeat (60) @(negedge clk);
    chk("R7 remaining count only", {7'd0, rdy_busy_n}, 8'd1);
    rd(11'h601, v); chk("R7 erase finished", v, 8'hFF);
  endtask

  task automatic t_hw_reset();
    logic [7:0] v;
    do_program(11'h302, 8'h00);
    @(negedge clk); hw_reset_n = 1'b0;
    repeat (10) @(negedge clk);
    chk("R8 oe off", {7'd0, rdata_oe}, 8'd0);
    chk("R8 busy shown", {7'd0, rdy_busy_n}, 8'd0);
    repeat (10) @(negedge clk); hw_reset_n = 1'b1;
    @(negedge clk);
    chk("R8 short pulse keeps op", {7'd0, rdy_busy_n}, 8'd0);
    repeat (PGM_CYC) @(negedge clk);
    rd(11'h302, v); chk("R8 short pulse program done", v, 8'h00);
    do_erase(11'h300);
    @(negedge clk); hw_reset_n = 1'b0;
    repeat (70) @(negedge clk); hw_reset_n = 1'b1;
    @(negedge clk);
    chk("R8 long pulse aborts", {7'd0, rdy_busy_n}, 8'd1);
    rd(11'h300, v); chk("R8 erase aborted", v, 8'hF0);
  endtask

  task automatic t_low_supply();
    logic [7:0] v;
    do_erase(11'h400);
    @(negedge clk); low_supply = 1'b1;
    @(negedge clk);
    chk("R9 op aborted", {7'd0, rdy_busy_n}, 8'd1);
    do_program(11'h401, 8'h00);
    chk("R9 writes ignored", {7'd0, rdy_busy_n}, 8'd1);
    @(negedge clk); low_supply = 1'b0;
    rd(11'h400, v); chk("R9 erase cut", v, 8'h00);
    rd(11'h401, v); chk("R9 program ignored", v, 8'hFF);
    wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55);
    @(negedge clk); low_supply = 1'b1;
    repeat (3) @(negedge clk); low_supply = 1'b0;
    wr(11'h555, 8'hA0); wr(11'h402, 8'h00);
    chk("R9 sequence dropped", {7'd0, rdy_busy_n}, 8'd1);
    rd(11'h402, v); chk("R9 no program", v, 8'hFF);
  endtask

  task automatic t_glitch();
    logic [7:0] v;
    wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'hA0);
    wr(11'h404, 8'h00, 1);
    chk("R10 glitch no start", {7'd0, rdy_busy_n}, 8'd1);
    wr(11'h404, 8'h0F, 2);
    chk("R10 real write starts", {7'd0, rdy_busy_n}, 8'd0);
    repeat (PGM_CYC + 10) @(negedge clk);
    rd(11'h404, v); chk("R10 glitch data unused", v, 8'h0F);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_program();
    t_erase();
    t_bad_seq();
    t_busy_ignore();
    t_suspend();
    t_hw_reset();
    t_low_supply();
    t_glitch();
    summary();
  end

endmodule